// File: doc/BRIEF.md
# Subnormal Single to Double Widener

This block takes a 32-bit single-precision word whose exponent field is all zero and whose fraction is nonzero, a subnormal value, and rewrites it as the equal 64-bit double-precision normal value. The result comes out as an upper and a lower 32-bit word, together with a register index pair: the upper word is meant for register n and the lower word for register n+1. The block is a helper beside a floating-point register file. It handles the one case where a narrow operand cannot simply be padded out to the wide format.

The caller pulses `start_i` with the operand and the target index. The unit then normalises the fraction with one left shift per clock. It starts from a fixed double-format exponent and lowers the exponent by one for each shift, until the hidden-bit position becomes set. It then pulses `done_o` with `wr_en_o` high and the packed words. An operand that does not qualify is answered one cycle later by `done_o` with `wr_en_o` low, and nothing is written.

Top module: `sp_subnorm_widen`

## Requirements
- R1: An operand qualifies for conversion only when bits 30:23 are all zero and bits 22:0 are not all zero. Bit 31 has no part in the decision, so both +0 (0x00000000) and -0 (0x80000000) are rejected.
- R2: A start with a non-qualifying operand raises `done_o` in the cycle after the accepting clock edge, with `wr_en_o` low.
- R3: Bit 31 of the upper result word equals bit 31 of the operand.
- R4: Bits 30:20 of the upper word hold 897 − s. Here s = 23 − p is the number of shifts, and p is the position of the highest set bit among operand bits 22:0.
- R5: The normalised fraction, with the hidden bit dropped, is split across the two words. Its top 20 bits fill bits 19:0 of the upper word, its low 3 bits fill bits 31:29 of the lower word, and lower-word bits 28:0 are zero. The two words together equal the double-precision encoding of the operand's value.
- R6: For a qualifying operand accepted at clock edge 0, `done_o` and `wr_en_o` are high for exactly one cycle, following edge s+1.
- R7: `wr_idx_o` carries the index given with the accepted start, and `wr_idx_next_o` carries that index plus one, modulo 16 (4-bit index).
- R8: `busy_o` is high from the edge that accepts a qualifying operand until the edge that raises `done_o`. A start while `busy_o` is high is ignored, and the running conversion's result and index are unchanged.
- R9: After reset `busy_o`, `done_o` and `wr_en_o` are low, and `wr_en_o` is never high without `done_o`.
- R10: The worst case is fraction 1 (p = 0). It takes 23 shifts, gives done after edge 24, and yields exponent 874.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe; taken only while not busy |
| operand_i | input | 32 | Single-precision operand |
| reg_idx_i | input | 4 | Destination index n for the upper word |
| busy_o | output | 1 | Normalisation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| wr_en_o | output | 1 | Result words valid for writing (only with done) |
| wr_idx_o | output | 4 | Index n for the upper word |
| wr_idx_next_o | output | 4 | Index n+1 for the lower word |
| wr_data_hi_o | output | 32 | Upper result word |
| wr_data_lo_o | output | 32 | Lower result word |

## Verification
The internal state is a shifted mantissa, a falling exponent counter and a one-bit phase. A fault in the counter appears as an exponent field off by some amount in the upper word. A fault in the stop test appears both as a wrong done latency and as a fraction shifted by the wrong amount. Either shows at the ports in the single done cycle, at most 24 cycles after the start. A phase register that fails to hold off new starts shows as a changed index or result for the conversion already running. Each fault therefore has a fixed time at which it must show: the done cycle of the affected conversion.

// File: rtl/sdw_pkg.sv
`timescale 1ns/1ps
package sdw_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_NORM = 1'b1
   } sdw_state_e;
endpackage

// File: rtl/sdw_classify.sv
`timescale 1ns/1ps
module sdw_classify #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W-1:0] mag_i,
   output logic                    eligible_o
);
   logic exp_zero;
   logic frac_nz;

   assign exp_zero   = (mag_i[EXP_W+FRAC_W-1 -: EXP_W] == '0);
   assign frac_nz    = |mag_i[FRAC_W-1:0];
   assign eligible_o = exp_zero & frac_nz;
endmodule

// File: rtl/sdw_normalize.sv
`timescale 1ns/1ps
module sdw_normalize
   import sdw_pkg::*;
#(
   parameter int FRAC_W    = 23,
   parameter int DEXP_W    = 11,
   parameter int START_EXP = 897
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic [FRAC_W-1:0] frac_i,
   output logic              busy_o,
   output logic              found_o,
   output logic [FRAC_W-1:0] frac_o,
   output logic [DEXP_W-1:0] exp_o
);
   sdw_state_e        state_q;
   logic [FRAC_W:0]   mant_q;
   logic [DEXP_W-1:0] exp_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         mant_q  <= '0;
         exp_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (load_i) begin
                  state_q <= ST_NORM;
                  mant_q  <= {1'b0, frac_i};
                  exp_q   <= DEXP_W'(START_EXP);
               end
            end
            ST_NORM: begin
               if (mant_q[FRAC_W]) begin
                  state_q <= ST_IDLE;
               end else begin
                  mant_q <= {mant_q[FRAC_W-1:0], 1'b0};
                  exp_q  <= exp_q - 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o  = (state_q == ST_NORM);
   assign found_o = (state_q == ST_NORM) && mant_q[FRAC_W];
   assign frac_o  = mant_q[FRAC_W-1:0];
   assign exp_o   = exp_q;
endmodule

// File: rtl/sdw_pack.sv
`timescale 1ns/1ps
module sdw_pack #(
   parameter int WORD_W    = 32,
   parameter int SP_FRAC_W = 23,
   parameter int DP_EXP_W  = 11
) (
   input  logic                 sign_i,
   input  logic [DP_EXP_W-1:0]  exp_i,
   input  logic [SP_FRAC_W-1:0] frac_i,
   output logic [WORD_W-1:0]    hi_o,
   output logic [WORD_W-1:0]    lo_o
);
   localparam int DP_FRAC_W = 2*WORD_W - 1 - DP_EXP_W;
   localparam int PAD_W     = DP_FRAC_W - SP_FRAC_W;

   logic [DP_FRAC_W-1:0] dp_frac;

   generate
      if (PAD_W > 0) begin : g_pad
         assign dp_frac = {frac_i, {PAD_W{1'b0}}};
      end else begin : g_nopad
         assign dp_frac = frac_i;
      end
   endgenerate

   assign {hi_o, lo_o} = {sign_i, exp_i, dp_frac};
endmodule

// File: rtl/sp_subnorm_widen.sv
`timescale 1ns/1ps
module sp_subnorm_widen #(
   parameter int WORD_W    = 32,
   parameter int SP_EXP_W  = 8,
   parameter int SP_FRAC_W = 23,
   parameter int DP_EXP_W  = 11,
   parameter int IDX_W     = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [WORD_W-1:0] operand_i,
   input  logic [IDX_W-1:0]  reg_idx_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              wr_en_o,
   output logic [IDX_W-1:0]  wr_idx_o,
   output logic [IDX_W-1:0]  wr_idx_next_o,
   output logic [WORD_W-1:0] wr_data_hi_o,
   output logic [WORD_W-1:0] wr_data_lo_o
);
   localparam int SP_BIAS   = 2**(SP_EXP_W-1) - 1;
   localparam int DP_BIAS   = 2**(DP_EXP_W-1) - 1;
   localparam int START_EXP = DP_BIAS - (SP_BIAS - 1);

   generate
      if (WORD_W != 1 + SP_EXP_W + SP_FRAC_W) begin : g_bad_word
         $error("sp_subnorm_widen: single format does not fill WORD_W");
      end
      if (2*WORD_W - 1 - DP_EXP_W < SP_FRAC_W) begin : g_bad_frac
         $error("sp_subnorm_widen: double fraction narrower than single fraction");
      end
      if (DP_EXP_W <= SP_EXP_W) begin : g_bad_exp
         $error("sp_subnorm_widen: double exponent must be wider");
      end
   endgenerate

   logic                 eligible;
   logic                 accept;
   logic                 norm_busy;
   logic                 found;
   logic [SP_FRAC_W-1:0] frac_w;
   logic [DP_EXP_W-1:0]  exp_w;
   logic [WORD_W-1:0]    hi_w;
   logic [WORD_W-1:0]    lo_w;
   logic                 sign_q;
   logic [IDX_W-1:0]     idx_q;
   logic                 done_q;
   logic                 wr_en_q;
   logic [IDX_W-1:0]     widx_q;
   logic [IDX_W-1:0]     wnext_q;
   logic [WORD_W-1:0]    hi_q;
   logic [WORD_W-1:0]    lo_q;

   assign accept = start_i & ~norm_busy;

   sdw_classify #(
      .EXP_W  (SP_EXP_W),
      .FRAC_W (SP_FRAC_W)
   ) u_classify (
      .mag_i      (operand_i[WORD_W-2:0]),
      .eligible_o (eligible)
   );

   sdw_normalize #(
      .FRAC_W    (SP_FRAC_W),
      .DEXP_W    (DP_EXP_W),
      .START_EXP (START_EXP)
   ) u_normalize (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (accept & eligible),
      .frac_i  (operand_i[SP_FRAC_W-1:0]),
      .busy_o  (norm_busy),
      .found_o (found),
      .frac_o  (frac_w),
      .exp_o   (exp_w)
   );

   sdw_pack #(
      .WORD_W    (WORD_W),
      .SP_FRAC_W (SP_FRAC_W),
      .DP_EXP_W  (DP_EXP_W)
   ) u_pack (
      .sign_i (sign_q),
      .exp_i  (exp_w),
      .frac_i (frac_w),
      .hi_o   (hi_w),
      .lo_o   (lo_w)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sign_q  <= 1'b0;
         idx_q   <= '0;
         done_q  <= 1'b0;
         wr_en_q <= 1'b0;
         widx_q  <= '0;
         wnext_q <= '0;
         hi_q    <= '0;
         lo_q    <= '0;
      end else begin
         done_q  <= 1'b0;
         wr_en_q <= 1'b0;
         if (accept) begin
            sign_q <= operand_i[WORD_W-1];
            idx_q  <= reg_idx_i;
            if (!eligible) begin
               done_q <= 1'b1;
            end
         end
         if (found) begin
            done_q  <= 1'b1;
            wr_en_q <= 1'b1;
            hi_q    <= hi_w;
            lo_q    <= lo_w;
            widx_q  <= idx_q;
            wnext_q <= idx_q + {{(IDX_W-1){1'b0}}, 1'b1};
         end
      end
   end

   assign busy_o        = norm_busy;
   assign done_o        = done_q;
   assign wr_en_o       = wr_en_q;
   assign wr_idx_o      = widx_q;
   assign wr_idx_next_o = wnext_q;
   assign wr_data_hi_o  = hi_q;
   assign wr_data_lo_o  = lo_q;
endmodule

// File: rtl/sp_subnorm_widen_chk.sv
`timescale 1ns/1ps
module sp_subnorm_widen_chk #(
   parameter int WORD_W    = 32,
   parameter int SP_EXP_W  = 8,
   parameter int SP_FRAC_W = 23,
   parameter int DP_EXP_W  = 11
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              start_i,
   input logic [WORD_W-1:0] operand_i,
   input logic              busy_o,
   input logic              done_o,
   input logic              wr_en_o,
   input logic [WORD_W-1:0] wr_data_hi_o,
   input logic [WORD_W-1:0] wr_data_lo_o
);
   localparam int START_EXP = (2**(DP_EXP_W-1) - 1) - (2**(SP_EXP_W-1) - 2);
   localparam int CNT_W     = $clog2(SP_FRAC_W + 2) + 1;
   localparam int LO_ZERO_W = 2*WORD_W - 1 - DP_EXP_W - SP_FRAC_W;

   logic             op_ok;
   logic             sign_hold;
   logic [CNT_W-1:0] busy_run;
   logic [DP_EXP_W-1:0] hi_exp;

   assign op_ok  = (operand_i[WORD_W-2 -: SP_EXP_W] == '0) && (operand_i[SP_FRAC_W-1:0] != '0);
   assign hi_exp = wr_data_hi_o[WORD_W-2 -: DP_EXP_W];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sign_hold <= 1'b0;
         busy_run  <= '0;
      end else begin
         if (start_i && !busy_o) sign_hold <= operand_i[WORD_W-1];
         busy_run <= busy_o ? busy_run + 1'b1 : '0;
      end
   end

   assert_reject_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && !busy_o && !op_ok) |=> (done_o && !wr_en_o));

   assert_accept_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && !busy_o && op_ok) |=> (busy_o && !done_o));

   assert_sign_kept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_o |-> (wr_data_hi_o[WORD_W-1] == sign_hold));

   assert_exp_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_o |-> (hi_exp >= DP_EXP_W'(START_EXP - SP_FRAC_W) && hi_exp <= DP_EXP_W'(START_EXP - 1)));

   assert_lo_tail_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_o |-> (wr_data_lo_o[LO_ZERO_W-1:0] == '0));

   assert_busy_ends_in_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |=> (busy_o || done_o));

   assert_done_not_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !busy_o);

   assert_wr_needs_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_o |-> done_o);

   assert_busy_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |-> (busy_run <= CNT_W'(SP_FRAC_W)));
endmodule

bind sp_subnorm_widen sp_subnorm_widen_chk #(
   .WORD_W    (WORD_W),
   .SP_EXP_W  (SP_EXP_W),
   .SP_FRAC_W (SP_FRAC_W),
   .DP_EXP_W  (DP_EXP_W)
) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .start_i      (start_i),
   .operand_i    (operand_i),
   .busy_o       (busy_o),
   .done_o       (done_o),
   .wr_en_o      (wr_en_o),
   .wr_data_hi_o (wr_data_hi_o),
   .wr_data_lo_o (wr_data_lo_o)
);

// File: tb/sp_subnorm_widen_bench.sv
`timescale 1ns/1ps
module sp_subnorm_widen_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] operand = '0;
   logic [3:0]  reg_idx = '0;
   logic        busy, done, wr_en;
   logic [3:0]  wr_idx, wr_idx_next;
   logic [31:0] hi, lo;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;

   always #2.5 clk = ~clk;

   sp_subnorm_widen u_sp_subnorm_widen (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .start_i       (start),
      .operand_i     (operand),
      .reg_idx_i     (reg_idx),
      .busy_o        (busy),
      .done_o        (done),
      .wr_en_o       (wr_en),
      .wr_idx_o      (wr_idx),
      .wr_idx_next_o (wr_idx_next),
      .wr_data_hi_o  (hi),
      .wr_data_lo_o  (lo)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // Value of a subnormal single is frac * 2^-149; scaling by halves is exact.
   function automatic logic [63:0] dbl_of(input logic [31:0] op);
      real r;
      r = real'(op[22:0]);
      for (int i = 0; i < 149; i++) r = r * 0.5;
      if (op[31]) r = -r;
      return $realtobits(r);
   endfunction

   function automatic int shifts_of(input logic [22:0] f);
      int s;
      s = 0;
      for (int p = 22; p >= 0; p--) begin
         if (f[p]) begin
            s = 23 - p;
            break;
         end
      end
      return s;
   endfunction

   task automatic convert(input logic [31:0] op, input logic [3:0] idx);
      logic        ok;
      int          lat;
      logic [63:0] e;
      int          s;
      ok = (op[30:23] == 8'h00) && (op[22:0] != 23'h0);
      e  = dbl_of(op);
      s  = shifts_of(op[22:0]);
      @(negedge clk);
      start = 1'b1; operand = op; reg_idx = idx;
      @(posedge clk);
      #1 start = 1'b0;
      lat = 0;
      @(negedge clk);
      chk("R8 busy after start", {63'd0, busy}, {63'd0, ok});
      while (!done && lat < 40) begin
         @(negedge clk);
         lat++;
      end
      if (ok) begin
         chk("R6 latency", 64'(lat), 64'(s + 1));
         chk("R1 write on qualifying", {63'd0, wr_en}, 64'd1);
         chk("R3 sign", {63'd0, hi[31]}, {63'd0, e[63]});
         chk("R4 exponent", {53'd0, hi[30:20]}, 64'(897 - s));
         chk("R5 hi fraction", {44'd0, hi[19:0]}, {44'd0, e[51:32]});
         chk("R5 lo word", {32'd0, lo}, {32'd0, e[31:0]});
         chk("R7 index n", {60'd0, wr_idx}, {60'd0, idx});
         chk("R7 index n+1", {60'd0, wr_idx_next}, {60'd0, 4'(idx + 4'd1)});
      end else begin
         chk("R2 reject latency", 64'(lat), 64'd0);
         chk("R2 no write", {63'd0, wr_en}, 64'd0);
      end
      @(negedge clk);
      chk("R6 done single pulse", {62'd0, done, wr_en}, 64'd0);
   endtask

   initial begin
      logic [31:0] lf;
      #12;
      chk("R9 reset busy", {63'd0, busy}, 64'd0);
      chk("R9 reset done", {63'd0, done}, 64'd0);
      chk("R9 reset wr_en", {63'd0, wr_en}, 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // single-bit fractions at every position, both signs
      for (int p = 0; p < 23; p++) begin
         convert({1'b0, 8'h00, 23'(1) << p}, 4'(p));
         convert({1'b1, 8'h00, 23'(1) << p}, 4'(p + 5));
      end

      // R10 worst case: fraction 1
      convert(32'h0000_0001, 4'd2);
      chk("R10 exponent 874", {53'd0, hi[30:20]}, 64'd874);
      convert(32'h007F_FFFF, 4'd15);   // R7 wrap to 0
      convert(32'h8055_5555, 4'd6);

      // R1/R2 rejected operands
      convert(32'h0000_0000, 4'd1);
      convert(32'h8000_0000, 4'd1);
      convert(32'h3F80_0000, 4'd1);
      convert(32'h0080_0000, 4'd1);
      convert(32'h7F80_0000, 4'd1);
      convert(32'h0180_0001, 4'd1);

      // pseudo-random subnormal and arbitrary words
      lf = 32'hACE1_2468;
      for (int k = 0; k < 300; k++) begin
         lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
         if (k % 3 == 0) convert(lf, lf[27:24]);
         else            convert({lf[31], 8'h00, lf[22:0]}, lf[27:24]);
      end

      // R8: start while busy is ignored
      @(negedge clk);
      start = 1'b1; operand = 32'h0000_0001; reg_idx = 4'd3;
      @(posedge clk);
      #1 start = 1'b0;
      repeat (5) @(negedge clk);
      start = 1'b1; operand = 32'h0040_0000; reg_idx = 4'd9;
      @(negedge clk);
      start = 1'b0;
      begin
         int w;
         w = 0;
         while (!done && w < 40) begin
            @(negedge clk);
            w++;
         end
      end
      chk("R8 result of first op kept", {hi, lo}, dbl_of(32'h0000_0001));
      chk("R8 index of first op kept", {60'd0, wr_idx}, 64'd3);
      begin
         int extra;
         extra = 0;
         repeat (30) begin
            @(negedge clk);
            if (done) extra++;
         end
         chk("R8 no done from ignored start", 64'(extra), 64'd0);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule